// File: doc/BRIEF.md
# Wormhole XY Route-and-Hold Unit

This unit handles the routing side of one input port of a router in a two-dimensional mesh that uses wormhole switching. Flits enter through a valid/ready stream and wait in a small FIFO. The flit at the head of the FIFO is offered on the output stream. When that flit opens a packet, the unit takes the destination coordinates from it and chooses one of five output ports. X is resolved first, and Y only after X matches. The unit keeps that choice for every later flit of the packet and drops it once the last flit has left.

The output stream carries the flit, a valid bit, and a one-hot port select. Each output port returns its own ready bit. A flit leaves only when `out_valid` is high and the ready bit of the selected port is high. Ready bits of ports that are not selected have no effect. While the selected port holds its ready low, the flit, the select and the valid bit stay frozen. Because every flit of the packet waits behind the head flit, a stalled header stalls the whole packet. On the input side, `in_ready` is high whenever the FIFO has a free slot. An input flit is written when `in_valid` and `in_ready` are both high. `in_flit` may change freely while `in_ready` is low.

Top module: `wxr_route_unit`

## Requirements
- R1: When the destination X and Y both equal `my_x` and `my_y`, the select is the local port, which is bit 0 of `out_sel`.
- R2: When `my_x` is less than the destination X, the select is East, which is bit 1.
- R3: When `my_x` is greater than the destination X, the select is West, which is bit 2.
- R4: When the X values are equal, the select is South (bit 4) if `my_y` is less than the destination Y, and North (bit 3) if `my_y` is greater.
- R5: Whenever the X values differ, the unit routes horizontally, whatever the Y values are.
- R6: While `out_valid` is high, `out_sel` has exactly one bit set, and `out_flit` is the oldest accepted flit that has not yet been sent.
- R7: The flit type sits in bits [15:14]: 00 is header, 01 is body, 10 is tail, 11 is a single-flit packet. The destination X sits in bits [5:3] and the destination Y in bits [2:0]. After a header is sent, body and tail flits use the header's port, whatever their own coordinate bits hold.
- R8: The held route is released when a tail flit or a single-flit packet is sent. The next header is then routed from its own coordinates.
- R9: A flit leaves only when `out_valid` is high and the `out_ready` bit of the selected port is high. Ready bits of other ports have no effect.
- R10: While `out_valid` is high and the selected port is not ready, `out_flit`, `out_sel` and `out_valid` keep their values at the next clock.
- R11: `in_ready` is low when the FIFO holds FIFO_DEPTH flits. While it is low, no input is taken.
- R12: After reset, `out_valid` is low, `in_ready` is high, and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | COORD_W | Router X coordinate (static) |
| my_y | input | COORD_W | Router Y coordinate (static) |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | FIFO has space |
| in_flit | input | FLIT_W | Input flit |
| out_valid | output | 1 | Head flit offered |
| out_flit | output | FLIT_W | Head flit |
| out_sel | output | 5 | One-hot port: 0 Local, 1 East, 2 West, 3 North, 4 South |
| out_ready | input | 5 | Per-port ready |

## Verification
The bench uses the default parameters: 16-bit flits, 3-bit coordinates and a two-entry FIFO. The router sits at (3,4), which leaves room for destinations on both sides of each axis, and also at the edges 0 and 7. With only two FIFO entries, the full condition is reached after two flits. This lets the bench check that `in_ready` drops while a held wormhole packet is still being drained through a port that is only partly ready.

// File: rtl/wxr_pkg.sv
package wxr_pkg;
  localparam int NUM_PORTS = 5;
  localparam int P_LOCAL = 0;
  localparam int P_EAST  = 1;
  localparam int P_WEST  = 2;
  localparam int P_NORTH = 3;
  localparam int P_SOUTH = 4;

  typedef enum logic [1:0] {
    FK_HEAD   = 2'b00,
    FK_BODY   = 2'b01,
    FK_TAIL   = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  function automatic logic closes_packet(input flit_kind_e k);
    return (k == FK_TAIL) || (k == FK_SINGLE);
  endfunction
endpackage

// File: rtl/wxr_flit_fifo.sv
module wxr_flit_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             full,
  output logic             nonempty,
  output logic [WIDTH-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full     = (count == FULL_CNT);
  assign nonempty = (count != '0);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/wxr_xy_calc.sv
module wxr_xy_calc
  import wxr_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0]   my_x,
  input  logic [COORD_W-1:0]   my_y,
  input  logic [COORD_W-1:0]   dst_x,
  input  logic [COORD_W-1:0]   dst_y,
  output logic [NUM_PORTS-1:0] port_sel
);
  always_comb begin
    port_sel = '0;
    if (my_x < dst_x)      port_sel[P_EAST]  = 1'b1;
    else if (my_x > dst_x) port_sel[P_WEST]  = 1'b1;
    else if (my_y < dst_y) port_sel[P_SOUTH] = 1'b1;
    else if (my_y > dst_y) port_sel[P_NORTH] = 1'b1;
    else                   port_sel[P_LOCAL] = 1'b1;
  end

  always_comb begin
    a_calc_onehot_r6: assert ($countones(port_sel) == 1);
  end
endmodule

// File: rtl/wxr_route_hold.sv
module wxr_route_hold
  import wxr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  flit_kind_e           head_kind,
  input  logic [NUM_PORTS-1:0] calc_sel,
  input  logic                 fire,
  output logic [NUM_PORTS-1:0] route_sel,
  output logic                 pkt_open
);
  logic [NUM_PORTS-1:0] held_sel;

  assign route_sel = pkt_open ? held_sel : calc_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_open <= 1'b0;
      held_sel <= '0;
    end else if (fire) begin
      if (!pkt_open && head_kind == FK_HEAD) begin
        pkt_open <= 1'b1;
        held_sel <= calc_sel;
      end else if (pkt_open && closes_packet(head_kind)) begin
        pkt_open <= 1'b0;
      end
    end
  end

  p_path_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pkt_open && head_kind == FK_HEAD) |=> (pkt_open && route_sel == $past(route_sel)));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pkt_open && closes_packet(head_kind)) |=> !pkt_open);
endmodule

// File: rtl/wxr_route_unit.sv
module wxr_route_unit
  import wxr_pkg::*;
#(
  parameter int FLIT_W     = 16,
  parameter int COORD_W    = 3,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [COORD_W-1:0]   my_x,
  input  logic [COORD_W-1:0]   my_y,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FLIT_W-1:0]    in_flit,
  output logic                 out_valid,
  output logic [FLIT_W-1:0]    out_flit,
  output logic [NUM_PORTS-1:0] out_sel,
  input  logic [NUM_PORTS-1:0] out_ready
);
  localparam int KIND_MSB = FLIT_W - 1;
  localparam int DX_LSB   = COORD_W;
  localparam int DY_LSB   = 0;

  logic       fifo_full, fifo_nonempty, fire, push, pkt_open;
  logic [FLIT_W-1:0] head;
  logic [NUM_PORTS-1:0] calc_sel;
  flit_kind_e head_kind;

  assign in_ready  = !fifo_full;
  assign push      = in_valid && in_ready;
  assign out_valid = fifo_nonempty;
  assign out_flit  = head;
  assign head_kind = flit_kind_e'(head[KIND_MSB -: 2]);
  assign fire      = out_valid && |(out_sel & out_ready);

  wxr_flit_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_flit),
    .pop(fire), .full(fifo_full), .nonempty(fifo_nonempty), .head(head)
  );

  wxr_xy_calc #(.COORD_W(COORD_W)) u_calc (
    .my_x(my_x), .my_y(my_y),
    .dst_x(head[DX_LSB +: COORD_W]), .dst_y(head[DY_LSB +: COORD_W]),
    .port_sel(calc_sel)
  );

  wxr_route_hold u_hold (
    .clk(clk), .rst_n(rst_n), .head_kind(head_kind), .calc_sel(calc_sel),
    .fire(fire), .route_sel(out_sel), .pkt_open(pkt_open)
  );

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_sel) == 1));
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fire) |=> (out_valid && $stable(out_flit) && $stable(out_sel)));
  p_busy_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_open && out_valid && head_kind != FK_HEAD) |-> !$isunknown(out_sel));
endmodule

// File: tb/wxr_route_unit_test.sv
module wxr_route_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] my_x = 3'd3, my_y = 3'd4;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_flit = '0;
  logic out_valid;
  logic [15:0] out_flit;
  logic [4:0] out_sel;
  logic [4:0] out_ready = '0;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  wxr_route_unit uut (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_flit(out_flit), .out_sel(out_sel),
    .out_ready(out_ready)
  );

  localparam logic [4:0] LOC = 5'b00001, EA = 5'b00010, WE = 5'b00100,
                         NO = 5'b01000, SO = 5'b10000;
  // {dst_x, dst_y, expected select}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {3'd3, 3'd4, LOC},  // R1
    {3'd5, 3'd4, EA},   // R2
    {3'd7, 3'd0, EA},   // R2 R5
    {3'd0, 3'd4, WE},   // R3
    {3'd1, 3'd7, WE},   // R3 R5
    {3'd3, 3'd6, SO},   // R4
    {3'd3, 3'd7, SO},   // R4
    {3'd3, 3'd1, NO},   // R4
    {3'd3, 3'd0, NO},   // R4
    {3'd4, 3'd4, EA}    // R5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [1:0] k, input logic [7:0] pay,
                                     input logic [2:0] dx, input logic [2:0] dy);
    return {k, pay, dx, dy};
  endfunction

  task automatic send(input logic [15:0] f);
    in_valid = 1'b1; in_flit = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] r);
    out_ready = r;
    @(negedge clk);
    out_ready = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 out_valid", 16'(out_valid), 16'd0);
    check("R12 in_ready", 16'(in_ready), 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] f;
      f = mk(2'b11, 8'(i * 17 + 1), VEC[i][10:8], VEC[i][7:5]);
      send(f);
      check($sformatf("R1-5 vec%0d valid", i), 16'(out_valid), 16'd1);
      check($sformatf("R6 vec%0d flit", i), out_flit, f);
      check($sformatf("R2/R3/R4 vec%0d sel", i), 16'(out_sel), 16'(VEC[i][4:0]));
      pulse(5'b11111);
      check($sformatf("R8 vec%0d drained", i), 16'(out_valid), 16'd0);
    end

    // Wormhole hold: header to East, body carries West-looking coords
    send(mk(2'b00, 8'h11, 3'd5, 3'd4));
    send(mk(2'b01, 8'h22, 3'd0, 3'd4));
    check("R11 full drops in_ready", 16'(in_ready), 16'd0);
    in_valid = 1'b1; in_flit = mk(2'b10, 8'h99, 3'd0, 3'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 header still head", out_flit, mk(2'b00, 8'h11, 3'd5, 3'd4));
    check("R2 header sel", 16'(out_sel), 16'(EA));
    pulse(WE | NO | SO | LOC);
    check("R9 wrong-port ready ignored", out_flit, mk(2'b00, 8'h11, 3'd5, 3'd4));
    check("R10 stall sel", 16'(out_sel), 16'(EA));
    check("R10 stall valid", 16'(out_valid), 16'd1);
    pulse(EA);
    check("R7 body flit", out_flit, mk(2'b01, 8'h22, 3'd0, 3'd4));
    check("R7 body keeps East", 16'(out_sel), 16'(EA));
    check("R11 space reopens", 16'(in_ready), 16'd1);
    send(mk(2'b10, 8'h33, 3'd3, 3'd4));
    pulse(EA);
    check("R7 tail flit", out_flit, mk(2'b10, 8'h33, 3'd3, 3'd4));
    check("R7 tail keeps East", 16'(out_sel), 16'(EA));
    pulse(EA);
    check("R8 packet drained", 16'(out_valid), 16'd0);
    send(mk(2'b00, 8'h44, 3'd3, 3'd2));
    check("R8 new header reroutes North", 16'(out_sel), 16'(NO));
    pulse(NO);
    send(mk(2'b10, 8'h55, 3'd6, 3'd6));
    check("R7 tail follows North hold", 16'(out_sel), 16'(NO));
    pulse(NO);
    send(mk(2'b11, 8'h66, 3'd3, 3'd4));
    check("R8 released to Local", 16'(out_sel), 16'(LOC));
    pulse(LOC);
    check("R6 empty at end", 16'(out_valid), 16'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule